// File: doc/BRIEF.md
# Dual-Edge Pulse and Period Capture

This block timestamps edges on a set of input signals against one shared 16-bit timer and turns each pair of timestamps into a 32-bit cycle count. Every capture pair watches one input pin. Its first channel records the timer on the starting edge and its second channel records it on the closing edge. The pair measures either the time between two like edges (period mode) or the time between a starting edge and the opposite edge (pulse mode). A polarity bit selects which edges are used in each case.

The timer counts from 0 up to the modulo value minus one and then starts again at 0. Each pair keeps its own count of timer wraps between its two edges, so a measurement can run past one timer period. A completed result is held in a per-pair register with a sticky done flag. Acknowledging the result clears done. If a second result lands before the acknowledge, an overrun flag is set. If the extended count does not fit in 32 bits, the result is forced to zero and a range flag is set.

Before edge detection, each input passes through a two-flop synchronizer and a glitch filter. The filter length is programmable. Pairs are fixed as channel 2n (first edge) and channel 2n+1 (second edge), so only even channel numbers can start a capture.

Top module: `capt_top`

## Requirements
- R1: An arm request is accepted only when exactly one of `capPeriod`/`capPulse` is set. A request with both bits set, or with neither, leaves the pair unarmed.
- R2: In period mode with `invert`=0, the result is the number of clock cycles between two successive rising edges of the pin.
- R3: In period mode with `invert`=1, the result is the number of cycles between two successive falling edges.
- R4: In pulse mode with `invert`=0, the result is the cycles from a rising edge to the next falling edge (high time). With `invert`=1, it is the cycles from a falling edge to the next rising edge (low time).
- R5: When the timer wraps between the two edges, the result equals wraps × modulo + second count − first count. It is therefore the true elapsed cycle count.
- R6: With `oneShot`=1, the pair leaves the armed state after its first result. Later edges produce no further result.
- R7: In continuous period mode, the closing edge of one measurement is also the opening edge of the next. Back-to-back periods are measured with no gap.
- R8: In continuous pulse mode, the pair re-arms after each result and waits for a new starting edge.
- R9: After reset, the modulo is 0xFFFF. A modulo write is ignored while any pair is armed, and a write of 0 is ignored. An accepted write takes effect on `curMod`.
- R10: An arm request to an already-armed pair does not change its mode. Arming clears the pair's done and overrun flags. A disarm request returns the pair to the unarmed state.
- R11: `done` is set by each result and stays set until `rdAck`. A result that arrives while `done` is still set also sets `overrun`.
- R12: With `filtLen`=N, a pin level that lasts fewer than N samples is ignored. A level that lasts N or more samples passes, and both edges see the same filter delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sigIn | input | PAIRS | Measured pins, one per pair |
| filtLen | input | FILT_W | Glitch filter length in samples |
| modWrEn | input | 1 | Modulo write strobe |
| modWrData | input | CNT_W | Modulo write value |
| curMod | output | CNT_W | Active modulo |
| armReq | input | PAIRS | Arm strobe per pair |
| disarmReq | input | PAIRS | Disarm strobe per pair |
| capPeriod | input | PAIRS | Select period measurement (sampled at arm) |
| capPulse | input | PAIRS | Select pulse measurement (sampled at arm) |
| oneShot | input | PAIRS | Stop after one result (sampled at arm) |
| invert | input | PAIRS | Use falling-edge polarity (sampled at arm) |
| rdAck | input | PAIRS | Result acknowledge, clears done |
| armed | output | PAIRS | Pair armed |
| done | output | PAIRS | Sticky result-ready flag |
| overrun | output | PAIRS | Result arrived while done was set |
| rangeErr | output | PAIRS | Last result exceeded 32 bits |
| result | output | PAIRS*32 | Results, pair n at bits 32n+31..32n |

## Verification
A pin edge reaches the pair's control after the two synchronizer flops, `filtLen` filter samples and the edge-detect register. Capture happens on the following clock edge, and the result, `done` and `overrun` registers update one cycle after that. Every result is therefore due within filtLen+5 cycles of the closing pin edge. Each directed task waits at least ten cycles after a closing edge before it samples, and always samples on the falling clock edge. The next stimulus edge in each task is placed well beyond that window. Expected counts come only from the cycle spacing the bench drives between edges, because the fixed input latency is the same for both edges and cancels out.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic [1:0] {PS_IDLE, PS_WAIT1, PS_WAIT2} pairState_t;

  typedef struct packed {
    logic loadFirst;
    logic finish;
    logic clrFlags;
  } pairStrobes_t;
endpackage

// File: rtl/capt_filter.sv
module capt_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic [FILT_W-1:0] filtLen,
  output logic              rise,
  output logic              fall
);
  logic syncA, syncB, filt, filtQ;
  logic [FILT_W-1:0] cnt;
  logic [FILT_W:0] nextCnt;

  assign nextCnt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      filt  <= 1'b0;
      filtQ <= 1'b0;
      cnt   <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      filtQ <= filt;
      if (syncB == filt) begin
        cnt <= '0;
      end else if (nextCnt >= {1'b0, filtLen}) begin
        filt <= syncB;
        cnt  <= '0;
      end else begin
        cnt <= nextCnt[FILT_W-1:0];
      end
    end
  end

  assign rise = filt & ~filtQ;
  assign fall = ~filt & filtQ;

  // R12: the filtered level only moves to a level the synchronizer already held
  assert_filter_follows_sync_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filt) |-> $past(syncB) == filt);
endmodule

// File: rtl/capt_timer.sv
module capt_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modWrEn,
  input  logic [CNT_W-1:0] modWrData,
  input  logic             anyArmed,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] curMod,
  output logic             wrap
);
  logic accept;

  assign accept = modWrEn && !anyArmed && (modWrData != '0);
  assign wrap   = (count == curMod - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curMod <= '1;
      count  <= '0;
    end else if (accept) begin
      curMod <= modWrData;
      count  <= '0;
    end else if (wrap) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  assert_mod_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curMod) |-> !$past(anyArmed));
  assert_count_below_mod_R9: assert property (@(posedge clk) disable iff (!rstN)
    count < curMod);
endmodule

// File: rtl/capt_pair_ctrl.sv
module capt_pair_ctrl
  import capt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         armReq,
  input  logic         disarmReq,
  input  logic         wantPeriod,
  input  logic         wantPulse,
  input  logic         oneShot,
  input  logic         invert,
  input  logic         rise,
  input  logic         fall,
  output pairStrobes_t strobes,
  output logic         armed
);
  pairState_t state;
  logic isPulse, oneShotQ, invQ;
  logic armOk, firstEdge, secondEdge;

  assign armOk      = armReq && !disarmReq && (state == PS_IDLE) && (wantPeriod ^ wantPulse);
  assign firstEdge  = invQ ? fall : rise;
  assign secondEdge = isPulse ? (invQ ? rise : fall) : firstEdge;

  always_comb begin
    strobes = '0;
    strobes.clrFlags = armOk;
    if (!disarmReq) begin
      strobes.finish    = (state == PS_WAIT2) && secondEdge;
      strobes.loadFirst = ((state == PS_WAIT1) && firstEdge) ||
                          ((state == PS_WAIT2) && secondEdge && !isPulse && !oneShotQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PS_IDLE;
      isPulse  <= 1'b0;
      oneShotQ <= 1'b0;
      invQ     <= 1'b0;
    end else if (disarmReq) begin
      state <= PS_IDLE;
    end else if (armOk) begin
      state    <= PS_WAIT1;
      isPulse  <= wantPulse;
      oneShotQ <= oneShot;
      invQ     <= invert;
    end else if (state == PS_WAIT1 && firstEdge) begin
      state <= PS_WAIT2;
    end else if (state == PS_WAIT2 && secondEdge) begin
      if (oneShotQ)     state <= PS_IDLE;
      else if (isPulse) state <= PS_WAIT1;
    end
  end

  assign armed = (state != PS_IDLE);

  assert_oneshot_stops_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish && oneShotQ |=> state == PS_IDLE);
  assert_bad_type_rejected_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_IDLE) && armReq && (wantPeriod == wantPulse) |=> state == PS_IDLE);
endmodule

// File: rtl/capt_pair_dp.sv
module capt_pair_dp
  import capt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WRAP_W = 16,
  parameter int RES_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pairStrobes_t     strobes,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] curMod,
  input  logic             wrap,
  input  logic             rdAck,
  output logic [RES_W-1:0] result,
  output logic             done,
  output logic             overrun,
  output logic             rangeErr
);
  localparam int FULL_W = WRAP_W + CNT_W + 2;

  logic [CNT_W-1:0]  firstCnt;
  logic [WRAP_W-1:0] wrapCnt;
  logic [FULL_W-1:0] prod, full;
  logic              tooBig;

  assign prod   = FULL_W'(wrapCnt) * FULL_W'(curMod);
  assign full   = prod + FULL_W'(count) - FULL_W'(firstCnt);
  assign tooBig = (|full[FULL_W-1:RES_W]) || (&wrapCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstCnt <= '0;
      wrapCnt  <= '0;
    end else if (strobes.loadFirst) begin
      firstCnt <= count;
      wrapCnt  <= wrap ? WRAP_W'(1) : '0;
    end else if (wrap && !(&wrapCnt)) begin
      wrapCnt <= wrapCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      done     <= 1'b0;
      overrun  <= 1'b0;
      rangeErr <= 1'b0;
    end else if (strobes.clrFlags) begin
      done    <= 1'b0;
      overrun <= 1'b0;
    end else if (strobes.finish) begin
      result   <= tooBig ? '0 : full[RES_W-1:0];
      rangeErr <= tooBig;
      done     <= 1'b1;
      overrun  <= overrun | (done & !rdAck);
    end else if (rdAck) begin
      done <= 1'b0;
    end
  end

  assert_done_from_finish_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(strobes.finish));
  assert_overrun_needs_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(done));
endmodule

// File: rtl/capt_top.sv
module capt_top
  import capt_pkg::*;
#(
  parameter int PAIRS  = 2,
  parameter int CNT_W  = 16,
  parameter int WRAP_W = 16,
  parameter int FILT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PAIRS-1:0]   sigIn,
  input  logic [FILT_W-1:0]  filtLen,
  input  logic               modWrEn,
  input  logic [CNT_W-1:0]   modWrData,
  output logic [CNT_W-1:0]   curMod,
  input  logic [PAIRS-1:0]   armReq,
  input  logic [PAIRS-1:0]   disarmReq,
  input  logic [PAIRS-1:0]   capPeriod,
  input  logic [PAIRS-1:0]   capPulse,
  input  logic [PAIRS-1:0]   oneShot,
  input  logic [PAIRS-1:0]   invert,
  input  logic [PAIRS-1:0]   rdAck,
  output logic [PAIRS-1:0]   armed,
  output logic [PAIRS-1:0]   done,
  output logic [PAIRS-1:0]   overrun,
  output logic [PAIRS-1:0]   rangeErr,
  output logic [PAIRS*32-1:0] result
);
  localparam int RES_W = 32;

  logic [CNT_W-1:0] count;
  logic             wrap;

  capt_timer #(.CNT_W(CNT_W)) i_timer (
    .clk(clk), .rstN(rstN), .modWrEn(modWrEn), .modWrData(modWrData),
    .anyArmed(|armed), .count(count), .curMod(curMod), .wrap(wrap)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic         rise, fall;
    pairStrobes_t strobes;

    capt_filter #(.FILT_W(FILT_W)) i_filter (
      .clk(clk), .rstN(rstN), .rawIn(sigIn[p]), .filtLen(filtLen),
      .rise(rise), .fall(fall)
    );

    capt_pair_ctrl i_ctrl (
      .clk(clk), .rstN(rstN), .armReq(armReq[p]), .disarmReq(disarmReq[p]),
      .wantPeriod(capPeriod[p]), .wantPulse(capPulse[p]), .oneShot(oneShot[p]),
      .invert(invert[p]), .rise(rise), .fall(fall), .strobes(strobes),
      .armed(armed[p])
    );

    capt_pair_dp #(.CNT_W(CNT_W), .WRAP_W(WRAP_W), .RES_W(RES_W)) i_dp (
      .clk(clk), .rstN(rstN), .strobes(strobes), .count(count), .curMod(curMod),
      .wrap(wrap), .rdAck(rdAck[p]), .result(result[p*RES_W +: RES_W]),
      .done(done[p]), .overrun(overrun[p]), .rangeErr(rangeErr[p])
    );
  end
endmodule

// File: tb/test_capt_top.sv
module test_capt_top;
  localparam int PAIRS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PAIRS-1:0] sigIn = '0, armReq = '0, disarmReq = '0, capPeriod = '0;
  logic [PAIRS-1:0] capPulse = '0, oneShot = '0, invert = '0, rdAck = '0;
  logic [3:0] filtLen = 4'd1;
  logic modWrEn = 1'b0;
  logic [15:0] modWrData = '0;
  logic [15:0] curMod;
  logic [PAIRS-1:0] armed, done, overrun, rangeErr;
  logic [PAIRS*32-1:0] result;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  capt_top i_capt_top (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .filtLen(filtLen), .modWrEn(modWrEn),
    .modWrData(modWrData), .curMod(curMod), .armReq(armReq), .disarmReq(disarmReq),
    .capPeriod(capPeriod), .capPulse(capPulse), .oneShot(oneShot), .invert(invert),
    .rdAck(rdAck), .armed(armed), .done(done), .overrun(overrun),
    .rangeErr(rangeErr), .result(result)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input int p, input logic per, input logic pul, input logic os, input logic inv);
    @(negedge clk);
    capPeriod[p] = per; capPulse[p] = pul; oneShot[p] = os; invert[p] = inv;
    armReq[p] = 1'b1;
    @(negedge clk);
    armReq[p] = 1'b0;
    cyc(2);
  endtask

  task automatic disarm(input int p);
    @(negedge clk); disarmReq[p] = 1'b1;
    @(negedge clk); disarmReq[p] = 1'b0;
  endtask

  task automatic ack(input int p);
    @(negedge clk); rdAck[p] = 1'b1;
    @(negedge clk); rdAck[p] = 1'b0;
  endtask

  task automatic drive(input int p, input logic lvl, input int n);
    @(negedge clk); sigIn[p] = lvl;
    cyc(n - 1);
  endtask

  task automatic writeMod(input logic [15:0] v);
    @(negedge clk); modWrEn = 1'b1; modWrData = v;
    @(negedge clk); modWrEn = 1'b0;
  endtask

  function automatic logic [31:0] res(input int p);
    return result[p*32 +: 32];
  endfunction

  task automatic t_reset;
    check("R9 reset modulo", 32'(curMod), 32'hFFFF);
    check("R11 reset done", 32'(done), 0);
    check("R10 reset armed", 32'(armed), 0);
  endtask

  task automatic t_arm_and_period;
    arm(0, 1, 1, 1, 0);
    check("R1 both types rejected", 32'(armed[0]), 0);
    arm(0, 0, 0, 1, 0);
    check("R1 no type rejected", 32'(armed[0]), 0);
    arm(0, 1, 0, 1, 0);
    check("R1 period accepted", 32'(armed[0]), 1);
    arm(0, 0, 1, 0, 0);  // R10: second arm must not switch to pulse mode
    drive(0, 1, 7); drive(0, 0, 13); drive(0, 1, 12);
    check("R2 period rise-to-rise", res(0), 20);
    check("R10 rearm ignored, done", 32'(done[0]), 1);
    check("R6 oneshot disarms", 32'(armed[0]), 0);
    ack(0);
    check("R11 ack clears done", 32'(done[0]), 0);
    drive(0, 0, 5); drive(0, 1, 6); drive(0, 0, 15);
    check("R6 no result after oneshot", 32'(done[0]), 0);
  endtask

  task automatic t_inverted;
    drive(1, 1, 10);
    arm(1, 1, 0, 1, 1);
    drive(1, 0, 9); drive(1, 1, 6); drive(1, 0, 12);
    check("R3 period fall-to-fall", res(1), 15);
    drive(1, 0, 5);
    arm(0, 0, 1, 1, 0);
    drive(0, 1, 11); drive(0, 0, 12);
    check("R4 high time", res(0), 11);
    drive(0, 1, 10);
    arm(0, 0, 1, 1, 1);
    drive(0, 0, 8); drive(0, 1, 12);
    check("R4 low time inverted", res(0), 8);
    drive(0, 0, 5);
  endtask

  task automatic t_continuous_period;
    arm(0, 1, 0, 0, 0);
    drive(0, 1, 20); drive(0, 0, 20); drive(0, 1, 10);
    check("R7 first period", res(0), 40);
    ack(0);
    cyc(8);
    drive(0, 0, 25); drive(0, 1, 10);
    check("R7 chained period", res(0), 45);
    check("R7 still armed", 32'(armed[0]), 1);
    disarm(0);
    check("R10 disarm", 32'(armed[0]), 0);
    drive(0, 0, 5);
  endtask

  task automatic t_continuous_pulse;
    arm(1, 0, 1, 0, 0);
    drive(1, 1, 5); drive(1, 0, 10); drive(1, 1, 9); drive(1, 0, 12);
    check("R11 overrun set", 32'(overrun[1]), 1);
    check("R8 second pulse result", res(1), 9);
    ack(1);
    check("R11 ack clears done", 32'(done[1]), 0);
    drive(1, 1, 4); drive(1, 0, 12);
    check("R8 rearmed pulse", res(1), 4);
    writeMod(16'd100);
    check("R9 write while armed ignored", 32'(curMod), 32'hFFFF);
    disarm(1);
    arm(1, 0, 1, 1, 0);
    check("R10 arm clears overrun", 32'(overrun[1]), 0);
    check("R10 arm clears done", 32'(done[1]), 0);
    disarm(1);
  endtask

  task automatic t_modulo_wrap;
    writeMod(16'd0);
    check("R9 zero write ignored", 32'(curMod), 32'hFFFF);
    writeMod(16'd50);
    check("R9 write accepted", 32'(curMod), 50);
    arm(0, 1, 0, 1, 0);
    drive(0, 1, 60); drive(0, 0, 63); drive(0, 1, 12);
    check("R5 period across wraps", res(0), 123);
    drive(0, 0, 5);
    arm(0, 0, 1, 1, 0);
    drive(0, 1, 200); drive(0, 0, 12);
    check("R5 pulse across wraps", res(0), 200);
    check("R5 no range error", 32'(rangeErr[0]), 0);
  endtask

  task automatic t_filter;
    filtLen = 4'd4;
    cyc(3);
    arm(0, 0, 1, 1, 0);
    drive(0, 1, 3); drive(0, 0, 15);
    check("R12 short glitch ignored", 32'(done[0]), 0);
    drive(0, 1, 10); drive(0, 0, 15);
    check("R12 filtered width", res(0), 10);
    check("R12 done", 32'(done[0]), 1);
    filtLen = 4'd1;
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    t_reset;
    t_arm_and_period;
    t_inverted;
    t_continuous_period;
    t_continuous_pulse;
    t_modulo_wrap;
    t_filter;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule